// File: doc/BRIEF.md
# SMBus Bus Timeout Monitor

This block watches the clock and data lines of a two-wire SMBus interface and flags two timing faults. The first is a clock-stuck-low condition. A down-counter is reloaded with a programmable count whenever the clock line is high. It counts system clocks only while the clock line is low. When it runs out, a one-cycle pulse tells the surrounding logic to reset the interface by disabling and then re-enabling it. For the usual 25 ms limit, the reload value is set to the number of system clocks in 25 ms minus one. A bench can use a small value instead.

The second fault is an idle bus. When both lines stay high for more than a set number of clock-source ticks, the bus is taken as free. The block then emits a one-cycle strobe that the protocol engine treats exactly like a detected STOP condition: it sets its STOP flag and raises its interrupt. Each detector has its own enable. Both raw lines first pass through a two-flop synchronizer. The interrupt controller and the protocol engine sit outside this block.

Top module: `smbus_timeout_monitor`

## Requirements
- R1: Both raw lines pass through a two-flop synchronizer before either detector uses them. With the clock line driven low and held, and low timeout enabled with reload N, `low_timeout_pulse` is first high after exactly N+3 rising clock edges following the input change.
- R2: After reset both outputs are 0. The synchronized lines start out high (idle bus).
- R3: While the synchronized clock line is high, the low-timeout counter is reloaded with `low_reload`. Low intervals shorter than N+1 cycles, separated by high time, never produce a pulse.
- R4: When low timeout is enabled, `low_timeout_pulse` is high for one cycle after N+1 consecutive cycles of low synchronized clock line, where N is `low_reload`. If the line stays low, the pulse repeats every N+1 cycles.
- R5: While `low_to_en` is 0, the low-timeout counter is held at its reload value and no low-timeout pulse is produced.
- R6: When free timeout is enabled, `free_stop_pulse` is high for one cycle after the (FREE_TICKS+1)-th `src_tick` seen while both synchronized lines are high. This is the strobe the protocol engine treats as a STOP (flag set, interrupt raised).
- R7: At most one `free_stop_pulse` is produced per continuous interval with both lines high.
- R8: While `free_to_en` is 0, the free-timeout counter is held at zero and no free pulse is produced.
- R9: A low sample on either line, SDA alone or SCL alone, clears the free-timeout count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_raw | input | 1 | Bus clock line, asynchronous |
| sda_raw | input | 1 | Bus data line, asynchronous |
| src_tick | input | 1 | One-cycle strobe per clock-source period |
| low_to_en | input | 1 | Enables the clock-low timeout detector |
| free_to_en | input | 1 | Enables the bus-free detector |
| low_reload | input | CNT_W | Reload count N; timeout after N+1 low cycles |
| low_timeout_pulse | output | 1 | One-cycle request to reset the interface |
| free_stop_pulse | output | 1 | One-cycle STOP-equivalent strobe on bus-free timeout |

## Verification
Assertions check on every cycle that:
- a low-timeout pulse only follows an enabled, low clock line;
- the counter holds the reload value after a high sample;
- a free pulse only follows a tick with both lines high and is never repeated in the next cycle;
- a low sample on either line or a cleared enable zeroes the free count.

The exact N+3 latency through the synchronizer, the repeat period while the line stays low, and the absence of a pulse for short or interrupted intervals depend on whole sequences. Only the bench scenarios, compared cycle by cycle against a behavioural model, can show them.

// File: rtl/smbto_pkg.sv
package smbto_pkg;

    typedef struct packed {
        logic scl;
        logic sda;
    } bus_lines_t;

    localparam int SYNC_STAGES = 2;

endpackage

// File: rtl/smbto_sync.sv
module smbto_sync
    import smbto_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES
) (
    input  logic       clk,
    input  logic       rst_n,
    input  bus_lines_t raw,
    output bus_lines_t synced
);

    typedef struct packed {
        bus_lines_t [STAGES-1:0] stg;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.stg[0] = raw;
        for (int i = 1; i < STAGES; i++) begin
            st_d.stg[i] = st_q.stg[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign synced = st_q.stg[STAGES-1];

    // R1: first stage captures the raw lines of the previous cycle
    assert_first_stage_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> st_q.stg[0] == $past(raw));

endmodule

// File: rtl/smbto_low_timer.sv
module smbto_low_timer #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             scl,
    input  logic [CNT_W-1:0] reload,
    output logic             expired
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pulse;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (!en || scl) begin
            st_d.cnt = reload;
        end else if (st_q.cnt == '0) begin
            st_d.pulse = 1'b1;
            st_d.cnt   = reload;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign expired = st_q.pulse;

    assert_pulse_needs_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse |-> $past(en && !scl));

    assert_reload_when_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && scl) |=> st_q.cnt == $past(reload));

    assert_quiet_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!st_q.pulse && st_q.cnt == $past(reload)));

    assert_single_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pulse && $past(reload) != '0) |=> !st_q.pulse);

endmodule

// File: rtl/smbto_free_det.sv
module smbto_free_det #(
    parameter int TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic scl,
    input  logic sda,
    input  logic tick,
    output logic free_hit
);

    localparam int            CW    = $clog2(TICKS + 2);
    localparam logic [CW-1:0] LIMIT = CW'(TICKS);
    localparam logic [CW-1:0] DONE  = CW'(TICKS + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pulse;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (!en || !(scl && sda)) begin
            st_d.cnt = '0;
        end else if (tick && st_q.cnt == LIMIT) begin
            st_d.pulse = 1'b1;
            st_d.cnt   = DONE;
        end else if (tick && st_q.cnt < LIMIT) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign free_hit = st_q.pulse;

    assert_hit_needs_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse |-> $past(en && scl && sda && tick));

    assert_once_per_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse |=> !st_q.pulse);

    assert_cleared_on_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl || !sda) |=> (st_q.cnt == '0 && !st_q.pulse));

    assert_held_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (st_q.cnt == '0 && !st_q.pulse));

    assert_count_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= DONE);

endmodule

// File: rtl/smbus_timeout_monitor.sv
module smbus_timeout_monitor
    import smbto_pkg::*;
#(
    parameter int CNT_W      = 20,
    parameter int FREE_TICKS = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_raw,
    input  logic             sda_raw,
    input  logic             src_tick,
    input  logic             low_to_en,
    input  logic             free_to_en,
    input  logic [CNT_W-1:0] low_reload,
    output logic             low_timeout_pulse,
    output logic             free_stop_pulse
);

    bus_lines_t raw_lines;
    bus_lines_t sync_lines;

    assign raw_lines.scl = scl_raw;
    assign raw_lines.sda = sda_raw;

    smbto_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (raw_lines),
        .synced (sync_lines)
    );

    smbto_low_timer #(.CNT_W(CNT_W)) i_low (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (low_to_en),
        .scl     (sync_lines.scl),
        .reload  (low_reload),
        .expired (low_timeout_pulse)
    );

    smbto_free_det #(.TICKS(FREE_TICKS)) i_free (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (free_to_en),
        .scl      (sync_lines.scl),
        .sda      (sync_lines.sda),
        .tick     (src_tick),
        .free_hit (free_stop_pulse)
    );

    // R2: the outputs never both fire from one bus state
    assert_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(low_timeout_pulse && free_stop_pulse));

endmodule

// File: tb/test_smbus_timeout_monitor.sv
module test_smbus_timeout_monitor;

    localparam int CNT_W = 8;
    localparam int FREE  = 10;
    localparam int N     = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_raw = 1'b1;
    logic sda_raw = 1'b1;
    logic src_tick = 1'b0;
    logic low_to_en = 1'b1;
    logic free_to_en = 1'b1;
    logic [CNT_W-1:0] low_reload = CNT_W'(N);
    logic low_timeout_pulse;
    logic free_stop_pulse;

    int checks = 0;
    int errors = 0;
    int low_seen = 0;
    int free_seen = 0;

    // behavioural reference state
    bit m_s1_scl = 1, m_s2_scl = 1, m_s1_sda = 1, m_s2_sda = 1;
    int m_lowrun = 0;
    int m_ticks = 0;
    bit m_fired = 0;
    bit exp_low = 0, exp_free = 0;

    always #5 clk = ~clk;

    smbus_timeout_monitor #(.CNT_W(CNT_W), .FREE_TICKS(FREE)) i_smbus_timeout_monitor (
        .clk               (clk),
        .rst_n             (rst_n),
        .scl_raw           (scl_raw),
        .sda_raw           (sda_raw),
        .src_tick          (src_tick),
        .low_to_en         (low_to_en),
        .free_to_en        (free_to_en),
        .low_reload        (low_reload),
        .low_timeout_pulse (low_timeout_pulse),
        .free_stop_pulse   (free_stop_pulse)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1_scl = 1; m_s2_scl = 1; m_s1_sda = 1; m_s2_sda = 1;
            m_lowrun = 0; m_ticks = 0; m_fired = 0;
            exp_low = 0; exp_free = 0;
        end else begin
            if (!low_to_en || m_s2_scl) begin
                m_lowrun = 0;
                exp_low  = 0;
            end else begin
                m_lowrun++;
                exp_low = (m_lowrun % (N + 1)) == 0;
            end
            exp_free = 0;
            if (!free_to_en || !(m_s2_scl && m_s2_sda)) begin
                m_ticks = 0;
                m_fired = 0;
            end else if (src_tick && !m_fired) begin
                m_ticks++;
                if (m_ticks == FREE + 1) begin
                    exp_free = 1;
                    m_fired  = 1;
                end
            end
            m_s2_scl = m_s1_scl; m_s1_scl = scl_raw;
            m_s2_sda = m_s1_sda; m_s1_sda = sda_raw;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // per-clock comparison against the model (R4 and R6 outputs)
    always @(negedge clk) begin
        if (rst_n) begin
            check("R4 low pulse vs model", int'(low_timeout_pulse), int'(exp_low));
            check("R6 free pulse vs model", int'(free_stop_pulse), int'(exp_free));
            if (low_timeout_pulse) low_seen++;
            if (free_stop_pulse) free_seen++;
        end
    end

    initial begin
        int k = 0;
        forever begin
            @(negedge clk); #1;
            src_tick = (k % 3) == 0;
            k++;
        end
    end

    task automatic drive(input bit c, input bit d, input int cycles);
        @(negedge clk); #1;
        scl_raw = c;
        sda_raw = d;
        repeat (cycles - 1) @(negedge clk);
    endtask

    task automatic zero_counts();
        @(negedge clk); #2;
        low_seen  = 0;
        free_seen = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #2;
        check("R2 low output after reset", int'(low_timeout_pulse), 0);
        check("R2 free output after reset", int'(free_stop_pulse), 0);

        // R1 latency through the synchronizer, R4 single cycle
        free_to_en = 1'b0;
        @(negedge clk); #1;
        scl_raw = 1'b0;
        repeat (N + 2) @(negedge clk);
        #2 check("R1 no pulse after N+2 edges", int'(low_timeout_pulse), 0);
        @(negedge clk); #2;
        check("R1 pulse after N+3 edges", int'(low_timeout_pulse), 1);
        @(negedge clk); #2;
        check("R4 pulse lasts one cycle", int'(low_timeout_pulse), 0);
        drive(1, 1, 10);

        // R4 repeat while low: 20 low cycles -> 2 pulses
        zero_counts();
        drive(0, 1, 20);
        drive(1, 1, 10);
        check("R4 repeated pulses while low", low_seen, 20 / (N + 1));

        // R3 reload while high
        zero_counts();
        drive(0, 1, N);
        drive(1, 1, 4);
        drive(0, 1, N);
        drive(1, 1, 10);
        check("R3 short low intervals give no pulse", low_seen, 0);

        // R5 low detector disabled
        zero_counts();
        low_to_en = 1'b0;
        drive(0, 1, 30);
        check("R5 disabled low detector", low_seen, 0);
        low_to_en = 1'b1;
        drive(0, 1, N + 3);
        check("R5 full count after enable", low_seen, 1);
        drive(1, 1, 5);

        // R6 and R7 free timeout
        free_to_en = 1'b1;
        drive(1, 0, 2);
        drive(1, 1, 1);
        zero_counts();
        repeat (60) @(negedge clk);
        check("R6 free timeout after idle", free_seen, 1);
        repeat (60) @(negedge clk);
        check("R7 one free pulse per interval", free_seen, 1);

        // R9 short dips on either line keep clearing the count
        zero_counts();
        for (int r = 0; r < 6; r++) begin
            if (r % 2 == 0) drive(1, 0, 1);
            else            drive(0, 1, 1);
            drive(1, 1, 20);
        end
        check("R9 dips on SDA or SCL clear count", free_seen, 0);

        // R8 free detector disabled
        free_to_en = 1'b0;
        drive(1, 0, 2);
        zero_counts();
        drive(1, 1, 80);
        check("R8 disabled free detector", free_seen, 0);
        free_to_en = 1'b1;
        repeat (60) @(negedge clk);
        check("R8 counts again after enable", free_seen, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule